// File: doc/BRIEF.md
# Microprogram Sequencer with Jump Logic

This block is the control unit of a small bus-based processor. It keeps a micro-program counter (the micro-state) and reads a control store of microinstructions addressed by it. Each microinstruction carries a 17-bit vector of control lines, which orders one register transfer on the shared bus. It also carries a 3-bit jump type and an absolute micro-address. The jump type alone chooses the next micro-state. The choices are the incremented address, the current address (to wait on a slow memory), the fixed fetch entry, an absolute target gated by the ALU zero flag, or a dispatch entry picked by the opcode of the instruction just loaded.

The surrounding datapath supplies the opcode field of its instruction register, the memory busy flag and the ALU zero flag. It takes the control vector back. The micro-state is also a port, so the program's path can be followed. The control store holds a four-state fetch routine and one execution routine for each supported opcode group. Every execution routine ends by returning to fetch.

Top module: `micro_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `uState` becomes 0 (the first fetch state) after that edge, whatever the other inputs are.
- R2: A microinstruction of jump type next makes `uState` advance by exactly one. Fetch runs as states 0, 1, 2, 3, and each execution routine runs through consecutive states.
- R3: A microinstruction of jump type spin holds `uState` while `memBusy` is high and advances it by one when `memBusy` is low. The spin states are 1 (instruction read), 13 (load data) and 18 (store data).
- R4: A microinstruction of jump type fetch moves `uState` to 0. Every execution routine ends with one: ALU 4..6, ALU-immediate 7..9, load 10..14, store 15..19, branch-if-zero 20..24, branch-if-nonzero 25..29, jump 30..32, jump-register 33..34, jump-and-link 35..38, jump-and-link-register 39..42.
- R5: State 3 dispatches on `opcode`. The mapping is 6'h00→4, 6'h08→7, 6'h23→10, 6'h2B→15, 6'h04→20, 6'h05→25, 6'h02→30, 6'h12→33, 6'h03→35, 6'h13→39.
- R6: Any other opcode in state 3 sends `uState` to 0.
- R7: In state 26 (jump type feqz), `uState` goes to the absolute target 0 when `aluZero` is high, and to 27 when it is low.
- R8: In state 21 (jump type fnez), `uState` goes to 22 when `aluZero` is high, and to the absolute target 0 when it is low.
- R9: The control layout has bit 0 load IR, bit 3 load memory address, bit 9 register read enable, bits 12:10 register select (3 = PC), bit 15 memory enable and bit 16 memory write. State 0 drives bits 3 and 9 with select 3. State 1 drives bits 0 and 15. State 18 drives bit 16, and state 13 does not drive it.
- R10: `opcode` has no effect on the next state outside the dispatch state, and `aluZero` has no effect outside the two conditional states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to the first fetch state |
| opcode | input | 6 | Opcode field of the loaded instruction |
| memBusy | input | 1 | Memory still working; spin states wait on it |
| aluZero | input | 1 | ALU result is zero; used by the conditional jumps |
| ctrl | output | 17 | Control lines for the current microinstruction |
| uState | output | 6 | Current micro-program address |

## Verification
A wrong micro-state shows at `uState` on the clock edge after the faulty choice. The same cycle, `ctrl` orders the wrong bus transfer. A bad jump type or target sends the path into another routine or back to fetch too early. A flaw in the spin, conditional or dispatch logic shows only when the matching input is at the value that matters. For that reason each branch state is driven with both flag values, and every dispatch entry is walked to its return to fetch.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UAW    = 6;
  localparam int OPW    = 6;
  localparam int CTRL_W = 17;

  typedef enum logic [2:0] {
    J_NEXT  = 3'd0,
    J_SPIN  = 3'd1,
    J_FETCH = 3'd2,
    J_DISP  = 3'd3,
    J_FEQZ  = 3'd4,
    J_FNEZ  = 3'd5
  } jump_t;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    jump_t             jt;
    logic [UAW-1:0]    target;
  } uword_t;

  typedef struct packed {
    logic selInc;
    logic selHold;
    logic selFetch;
    logic selAbs;
    logic selDisp;
  } seqStrobe_t;

  // control-line bit positions
  localparam int B_LDIR  = 0;
  localparam int B_LDA   = 1;
  localparam int B_LDB   = 2;
  localparam int B_LDMA  = 3;
  localparam int B_ALUOP = 4;   // 3 bits
  localparam int B_ENALU = 7;
  localparam int B_REGWR = 8;
  localparam int B_ENREG = 9;
  localparam int B_RSEL  = 10;  // 3 bits
  localparam int B_IMM   = 13;  // 2 bits, 0 = off
  localparam int B_ENMEM = 15;
  localparam int B_MEMWR = 16;

  localparam logic [2:0] RS_RS = 3'd0, RS_RT = 3'd1, RS_RD = 3'd2, RS_PC = 3'd3, RS_LINK = 3'd4;
  localparam logic [2:0] AO_PASSA = 3'd0, AO_PASSB = 3'd1, AO_INC4 = 3'd2,
                         AO_ADD = 3'd3, AO_FUNC = 3'd4, AO_JTARG = 3'd5;
  localparam logic [1:0] IM_SEXT = 2'd1, IM_SEXT_SH2 = 2'd2, IM_RAW = 2'd3;

  // micro-address map
  localparam logic [UAW-1:0] UA_FETCH = 6'd0;
  localparam logic [UAW-1:0] UA_ALU   = 6'd4;
  localparam logic [UAW-1:0] UA_ALUI  = 6'd7;
  localparam logic [UAW-1:0] UA_LW    = 6'd10;
  localparam logic [UAW-1:0] UA_SW    = 6'd15;
  localparam logic [UAW-1:0] UA_BEQZ  = 6'd20;
  localparam logic [UAW-1:0] UA_BNEZ  = 6'd25;
  localparam logic [UAW-1:0] UA_J     = 6'd30;
  localparam logic [UAW-1:0] UA_JR    = 6'd33;
  localparam logic [UAW-1:0] UA_JAL   = 6'd35;
  localparam logic [UAW-1:0] UA_JALR  = 6'd39;

  function automatic logic [CTRL_W-1:0] bitOn(input int pos);
    return CTRL_W'(1) << pos;
  endfunction

  function automatic logic [CTRL_W-1:0] rdReg(input logic [2:0] sel);
    return bitOn(B_ENREG) | (CTRL_W'(sel) << B_RSEL);
  endfunction

  function automatic logic [CTRL_W-1:0] wrReg(input logic [2:0] sel);
    return bitOn(B_REGWR) | (CTRL_W'(sel) << B_RSEL);
  endfunction

  function automatic logic [CTRL_W-1:0] aluDrv(input logic [2:0] op);
    return bitOn(B_ENALU) | (CTRL_W'(op) << B_ALUOP);
  endfunction

  function automatic logic [CTRL_W-1:0] immDrv(input logic [1:0] sel);
    return CTRL_W'(sel) << B_IMM;
  endfunction

  function automatic logic [UAW-1:0] dispatchEntry(input logic [OPW-1:0] op);
    case (op)
      6'h00:   return UA_ALU;
      6'h08:   return UA_ALUI;
      6'h23:   return UA_LW;
      6'h2B:   return UA_SW;
      6'h04:   return UA_BEQZ;
      6'h05:   return UA_BNEZ;
      6'h02:   return UA_J;
      6'h12:   return UA_JR;
      6'h03:   return UA_JAL;
      6'h13:   return UA_JALR;
      default: return UA_FETCH;
    endcase
  endfunction
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import useq_pkg::*;
#(
  parameter int AW = UAW
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  function automatic uword_t mk(input jump_t jt, input logic [CTRL_W-1:0] c);
    uword_t w;
    w.ctrl   = c;
    w.jt     = jt;
    w.target = UA_FETCH;
    return w;
  endfunction

  always_comb begin
    case (addr)
      // instruction fetch
      6'd0:  word = mk(J_NEXT,  rdReg(RS_PC) | bitOn(B_LDMA));
      6'd1:  word = mk(J_SPIN,  bitOn(B_ENMEM) | bitOn(B_LDIR));
      6'd2:  word = mk(J_NEXT,  rdReg(RS_PC) | bitOn(B_LDA));
      6'd3:  word = mk(J_DISP,  aluDrv(AO_INC4) | wrReg(RS_PC));
      // register ALU
      6'd4:  word = mk(J_NEXT,  rdReg(RS_RS) | bitOn(B_LDA));
      6'd5:  word = mk(J_NEXT,  rdReg(RS_RT) | bitOn(B_LDB));
      6'd6:  word = mk(J_FETCH, aluDrv(AO_FUNC) | wrReg(RS_RD));
      // immediate ALU
      6'd7:  word = mk(J_NEXT,  rdReg(RS_RS) | bitOn(B_LDA));
      6'd8:  word = mk(J_NEXT,  immDrv(IM_SEXT) | bitOn(B_LDB));
      6'd9:  word = mk(J_FETCH, aluDrv(AO_FUNC) | wrReg(RS_RT));
      // load
      6'd10: word = mk(J_NEXT,  rdReg(RS_RS) | bitOn(B_LDA));
      6'd11: word = mk(J_NEXT,  immDrv(IM_SEXT) | bitOn(B_LDB));
      6'd12: word = mk(J_NEXT,  aluDrv(AO_ADD) | bitOn(B_LDMA));
      6'd13: word = mk(J_SPIN,  bitOn(B_ENMEM) | wrReg(RS_RT));
      6'd14: word = mk(J_FETCH, '0);
      // store
      6'd15: word = mk(J_NEXT,  rdReg(RS_RS) | bitOn(B_LDA));
      6'd16: word = mk(J_NEXT,  immDrv(IM_SEXT) | bitOn(B_LDB));
      6'd17: word = mk(J_NEXT,  aluDrv(AO_ADD) | bitOn(B_LDMA));
      6'd18: word = mk(J_SPIN,  bitOn(B_ENMEM) | bitOn(B_MEMWR) | rdReg(RS_RT));
      6'd19: word = mk(J_FETCH, '0);
      // branch taken on zero
      6'd20: word = mk(J_NEXT,  rdReg(RS_RS) | bitOn(B_LDA));
      6'd21: word = mk(J_FNEZ,  '0);
      6'd22: word = mk(J_NEXT,  rdReg(RS_PC) | bitOn(B_LDA));
      6'd23: word = mk(J_NEXT,  immDrv(IM_SEXT_SH2) | bitOn(B_LDB));
      6'd24: word = mk(J_FETCH, aluDrv(AO_ADD) | wrReg(RS_PC));
      // branch taken on nonzero
      6'd25: word = mk(J_NEXT,  rdReg(RS_RS) | bitOn(B_LDA));
      6'd26: word = mk(J_FEQZ,  '0);
      6'd27: word = mk(J_NEXT,  rdReg(RS_PC) | bitOn(B_LDA));
      6'd28: word = mk(J_NEXT,  immDrv(IM_SEXT_SH2) | bitOn(B_LDB));
      6'd29: word = mk(J_FETCH, aluDrv(AO_ADD) | wrReg(RS_PC));
      // jump
      6'd30: word = mk(J_NEXT,  rdReg(RS_PC) | bitOn(B_LDA));
      6'd31: word = mk(J_NEXT,  immDrv(IM_RAW) | bitOn(B_LDB));
      6'd32: word = mk(J_FETCH, aluDrv(AO_JTARG) | wrReg(RS_PC));
      // jump register
      6'd33: word = mk(J_NEXT,  rdReg(RS_RS) | bitOn(B_LDA));
      6'd34: word = mk(J_FETCH, aluDrv(AO_PASSA) | wrReg(RS_PC));
      // jump and link
      6'd35: word = mk(J_NEXT,  rdReg(RS_PC) | bitOn(B_LDA));
      6'd36: word = mk(J_NEXT,  aluDrv(AO_PASSA) | wrReg(RS_LINK));
      6'd37: word = mk(J_NEXT,  immDrv(IM_RAW) | bitOn(B_LDB));
      6'd38: word = mk(J_FETCH, aluDrv(AO_JTARG) | wrReg(RS_PC));
      // jump and link register
      6'd39: word = mk(J_NEXT,  rdReg(RS_PC) | bitOn(B_LDA));
      6'd40: word = mk(J_NEXT,  rdReg(RS_RS) | bitOn(B_LDB));
      6'd41: word = mk(J_NEXT,  aluDrv(AO_PASSA) | wrReg(RS_LINK));
      6'd42: word = mk(J_FETCH, aluDrv(AO_PASSB) | wrReg(RS_PC));
      default: word = mk(J_FETCH, '0);
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  jump_t      jt,
  input  logic       memBusy,
  input  logic       aluZero,
  output seqStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    unique case (jt)
      J_NEXT:  strobe.selInc   = 1'b1;
      J_SPIN:  begin
        strobe.selHold = memBusy;
        strobe.selInc  = !memBusy;
      end
      J_FETCH: strobe.selFetch = 1'b1;
      J_DISP:  strobe.selDisp  = 1'b1;
      J_FEQZ:  begin
        strobe.selAbs = aluZero;
        strobe.selInc = !aluZero;
      end
      J_FNEZ:  begin
        strobe.selInc = aluZero;
        strobe.selAbs = !aluZero;
      end
      default: strobe.selFetch = 1'b1;
    endcase
  end
endmodule

// File: rtl/useq_path.sv
module useq_path
  import useq_pkg::*;
#(
  parameter int AW  = UAW,
  parameter int OW  = OPW
) (
  input  logic          clk,
  input  logic          rst,
  input  seqStrobe_t    strobe,
  input  logic [AW-1:0] target,
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] uPC
);
  logic [AW-1:0] uNext;
  logic [AW-1:0] dispAddr;

  assign dispAddr = dispatchEntry(opcode);

  always_comb begin
    if (strobe.selHold)       uNext = uPC;
    else if (strobe.selFetch) uNext = UA_FETCH;
    else if (strobe.selAbs)   uNext = target;
    else if (strobe.selDisp)  uNext = dispAddr;
    else                      uNext = uPC + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) uPC <= UA_FETCH;
    else     uPC <= uNext;
  end

  // R1
  reset_to_fetch_chk: assert property (@(posedge clk) rst |=> (uPC == UA_FETCH));
endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer
  import useq_pkg::*;
#(
  parameter int AW = UAW,
  parameter int OW = OPW,
  parameter int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode,
  input  logic          memBusy,
  input  logic          aluZero,
  output logic [CW-1:0] ctrl,
  output logic [AW-1:0] uState
);
  uword_t     word;
  seqStrobe_t strobe;

  ucode_rom #(.AW(AW)) u_rom (
    .addr (uState),
    .word (word)
  );

  useq_ctrl u_ctrl (
    .jt      (word.jt),
    .memBusy (memBusy),
    .aluZero (aluZero),
    .strobe  (strobe)
  );

  useq_path #(.AW(AW), .OW(OW)) u_path (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .target (word.target),
    .opcode (opcode),
    .uPC    (uState)
  );

  assign ctrl = word.ctrl;

  // R2
  next_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (word.jt == J_NEXT) |=> (uState == AW'($past(uState) + AW'(1))));
  // R3
  spin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (word.jt == J_SPIN && memBusy) |=> $stable(uState));
  // R3
  spin_release_chk: assert property (@(posedge clk) disable iff (rst)
    (word.jt == J_SPIN && !memBusy) |=> (uState == AW'($past(uState) + AW'(1))));
  // R4
  fetch_return_chk: assert property (@(posedge clk) disable iff (rst)
    (word.jt == J_FETCH) |=> (uState == UA_FETCH));
  // R7
  feqz_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (word.jt == J_FEQZ && aluZero) |=> (uState == $past(word.target)));
  // R8
  fnez_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (word.jt == J_FNEZ && !aluZero) |=> (uState == $past(word.target)));
endmodule

// File: tb/micro_sequencer_tb.sv
`timescale 1ns/100ps
module micro_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = 6'h00;
  logic        memBusy = 1'b0;
  logic        aluZero = 1'b0;
  logic [16:0] ctrl;
  logic [5:0]  uState;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  micro_sequencer u_dut (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .memBusy (memBusy),
    .aluZero (aluZero),
    .ctrl    (ctrl),
    .uState  (uState)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chkState(input logic [5:0] exp, input string req);
    nChecks++;
    if (uState !== exp) begin
      nFails++;
      $display("FAIL %s: uState actual %0d expected %0d", req, uState, exp);
    end
  endtask

  task automatic chkBit(input logic act, input logic exp, input string req, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  // from state 0 through fetch to state 3, holding FETCH1 for nBusy extra cycles
  task automatic runFetch(input int nBusy, input logic [5:0] op);
    chkState(6'd0, "R2");
    opcode = op;
    tick(); chkState(6'd1, "R2");
    memBusy = 1'b1;
    for (int i = 0; i < nBusy; i++) begin
      tick(); chkState(6'd1, "R3");
    end
    memBusy = 1'b0;
    tick(); chkState(6'd2, "R3");
    tick(); chkState(6'd3, "R2");
  endtask

  // from the entry state, walk to the last state then back to fetch
  task automatic walk(input logic [5:0] first, input logic [5:0] last);
    for (int s = first + 1; s <= last; s++) begin
      tick(); chkState(6'(s), "R2");
    end
    tick(); chkState(6'd0, "R4");
  endtask

  task automatic testReset();
    rst = 1'b1; opcode = 6'h23; memBusy = 1'b1; aluZero = 1'b1;
    tick(); tick();
    chkState(6'd0, "R1");
    memBusy = 1'b0; aluZero = 1'b0;
    rst = 1'b0;
    #1;
    chkBit(ctrl[3], 1'b1, "R9", "ldMA in state 0");
    chkBit(ctrl[9], 1'b1, "R9", "reg read in state 0");
    nChecks++;
    if (ctrl[12:10] !== 3'd3) begin
      nFails++;
      $display("FAIL R9: register select actual %0d expected 3", ctrl[12:10]);
    end
  endtask

  task automatic testAluIgnoresOpcode();
    runFetch(0, 6'h00);
    tick(); chkState(6'd4, "R5");
    opcode = 6'h23; aluZero = 1'b1;   // R10: no effect outside dispatch
    tick(); chkState(6'd5, "R10");
    opcode = 6'h3F; aluZero = 1'b0;
    tick(); chkState(6'd6, "R10");
    tick(); chkState(6'd0, "R4");
  endtask

  task automatic testAluiBusy();
    runFetch(3, 6'h08);
    tick(); chkState(6'd7, "R5");
    walk(6'd7, 6'd9);
  endtask

  task automatic testFetchCtrl();
    opcode = 6'h2B;
    tick(); chkState(6'd1, "R2");
    chkBit(ctrl[0], 1'b1, "R9", "ldIR in state 1");
    chkBit(ctrl[15], 1'b1, "R9", "enMem in state 1");
    tick(); tick(); tick(); chkState(6'd15, "R5");
    tick(); tick(); tick(); chkState(6'd18, "R2");
    chkBit(ctrl[16], 1'b1, "R9", "memWr in state 18");
    memBusy = 1'b1;
    tick(); chkState(6'd18, "R3");
    memBusy = 1'b0;
    tick(); chkState(6'd19, "R3");
    tick(); chkState(6'd0, "R4");
  endtask

  task automatic testLoad();
    runFetch(1, 6'h23);
    tick(); chkState(6'd10, "R5");
    tick(); tick(); tick(); chkState(6'd13, "R2");
    chkBit(ctrl[16], 1'b0, "R9", "memWr in state 13");
    memBusy = 1'b1;
    tick(); chkState(6'd13, "R3");
    tick(); chkState(6'd13, "R3");
    memBusy = 1'b0;
    tick(); chkState(6'd14, "R3");
    tick(); chkState(6'd0, "R4");
  endtask

  task automatic testBeqz(input logic z);
    runFetch(0, 6'h04);
    tick(); chkState(6'd20, "R5");
    tick(); chkState(6'd21, "R2");
    aluZero = z;
    tick();
    aluZero = ~z;   // R10: later states ignore it
    if (z) begin
      chkState(6'd22, "R8");
      walk(6'd22, 6'd24);
    end else begin
      chkState(6'd0, "R8");
    end
    aluZero = 1'b0;
  endtask

  task automatic testBnez(input logic z);
    runFetch(0, 6'h05);
    tick(); chkState(6'd25, "R5");
    tick(); chkState(6'd26, "R2");
    aluZero = z;
    tick();
    aluZero = ~z;
    if (z) begin
      chkState(6'd0, "R7");
    end else begin
      chkState(6'd27, "R7");
      walk(6'd27, 6'd29);
    end
    aluZero = 1'b0;
  endtask

  task automatic testJump(input logic [5:0] op, input logic [5:0] first, input logic [5:0] last);
    runFetch(0, op);
    tick(); chkState(first, "R5");
    walk(first, last);
  endtask

  task automatic testUnknown(input logic [5:0] op);
    runFetch(0, op);
    tick(); chkState(6'd0, "R6");
  endtask

  task automatic testMidReset();
    runFetch(0, 6'h23);
    tick(); tick(); chkState(6'd11, "R2");
    rst = 1'b1; memBusy = 1'b1;
    tick(); chkState(6'd0, "R1");
    rst = 1'b0; memBusy = 1'b0;
  endtask

  initial begin
    testReset();
    testAluIgnoresOpcode();
    testAluiBusy();
    testFetchCtrl();
    testLoad();
    testBeqz(1'b1);
    testBeqz(1'b0);
    testBnez(1'b1);
    testBnez(1'b0);
    testJump(6'h02, 6'd30, 6'd32);
    testJump(6'h12, 6'd33, 6'd34);
    testJump(6'h03, 6'd35, 6'd38);
    testJump(6'h13, 6'd39, 6'd42);
    testUnknown(6'h3F);
    testUnknown(6'h01);
    testMidReset();
    testAluIgnoresOpcode();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule